// File: doc/BRIEF.md
# Two-Tier DMA Channel Priority Arbiter

This block chooses which of a set of DMA channels the transfer engine serves next. Each channel has a request line and an enable line, plus a one-bit priority level that is either default or high. Software changes the levels through two write strobes. One strobe raises the channels whose data bits are one. The other strobe lowers the channels whose data bits are one.

Whenever the transfer engine pulses its arbitrate input, the block looks at all enabled requesters. A high-level requester always wins over a default-level one. Inside a level, the smallest channel number wins. The chosen channel is registered as a one-hot grant, an encoded number and a valid flag. These outputs hold their value until the next pulse, so the engine can work on one channel while requests keep changing. The scheme is fixed priority. It has no rotation and no fairness.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While `rst` is high, and after it until the first arbitrate pulse, `grant_vld` is 0, `grant_oh` is all zeros and `grant_ch` is 0. All channel levels reset to default.
- R2: A cycle with `lvl_set_we` high raises channel i to high level for every bit i of `lvl_set_data` that is 1. Bits that are 0 leave their channels unchanged.
- R3: A cycle with `lvl_clr_we` high returns channel i to default level for every bit i of `lvl_clr_data` that is 1. Bits that are 0 leave their channels unchanged.
- R4: If a set and a clear hit the same bit in the same cycle, that channel ends at high level.
- R5: When at least one eligible requester is at high level, the grant goes to a high-level channel, whatever its number.
- R6: Within the winning level, the grant goes to the eligible channel with the lowest number.
- R7: A channel counts as eligible only when both its `req` bit and its `ch_en` bit are 1. A disabled channel is never granted.
- R8: An arbitrate pulse with no eligible channel gives `grant_vld` = 0, `grant_oh` = 0 and `grant_ch` = 0.
- R9: The grant outputs change only on the clock edge at which `arb_pulse` is high. They then reflect the requests, enables and levels present before that edge; a level write on that same edge affects only later pulses. Between pulses the outputs hold.
- R10: When `grant_vld` is 1, exactly one bit of `grant_oh` is set, and `grant_ch` is the index of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_CH | Per-channel transfer request |
| ch_en | input | NUM_CH | Per-channel enable mask |
| lvl_set_we | input | 1 | Strobe: raise the levels marked in `lvl_set_data` |
| lvl_set_data | input | NUM_CH | Bit mask of channels to raise to high level |
| lvl_clr_we | input | 1 | Strobe: lower the levels marked in `lvl_clr_data` |
| lvl_clr_data | input | NUM_CH | Bit mask of channels to return to default level |
| arb_pulse | input | 1 | Compute and register a new grant |
| grant_oh | output | NUM_CH | Registered one-hot grant |
| grant_ch | output | CH_W | Registered number of the granted channel |
| grant_vld | output | 1 | Registered flag: the grant is valid |

## Verification
The bench builds the arbiter with NUM_CH = 6. At that size every combination of level pattern and request pattern, 4096 pairs, can be swept with all channels enabled. A second full sweep covers every enable pattern against every request pattern under a mixed level pattern. Together these sweeps reach every tier conflict, every tie inside a tier and every masking case, and each grant is compared with a reference computed in the bench. Directed sequences cover what the sweeps do not: outputs holding between pulses, a level write on the same edge as a pulse, writes of zero bits, and a set and a clear that collide.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic {
    LVL_DEFAULT = 1'b0,
    LVL_HIGH    = 1'b1
  } prio_lvl_e;

  // Width of a channel index, never below one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dpa_level_reg.sv
module dpa_level_reg #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic [W-1:0] set_data,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] lvl
);
  logic [W-1:0] set_mask, clr_mask, lvl_q;

  assign set_mask = set_we ? set_data : '0;
  assign clr_mask = clr_we ? clr_data : '0;

  // Clear applied first, set ORed after: set wins on a collision.
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= {W{dpa_pkg::LVL_DEFAULT}};
    else     lvl_q <= (lvl_q & ~clr_mask) | set_mask;
  end

  assign lvl = lvl_q;

  assert_set_raises_R2: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((lvl & $past(set_data)) == $past(set_data)));

  assert_clr_lowers_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((lvl & $past(clr_data)) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (set_we && clr_we) |=> ((lvl & $past(set_data & clr_data)) == $past(set_data & clr_data)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(lvl));
endmodule

// File: rtl/dpa_low_pick.sv
module dpa_low_pick #(
  parameter int unsigned W = 14
) (
  input  logic [W-1:0] cand,
  output logic [W-1:0] pick_oh,
  output logic         any
);
  logic [W:0] seen;

  assign seen[0] = 1'b0;

  // Prefix chain: a bit is picked when no lower bit was a candidate.
  for (genvar i = 0; i < W; i++) begin : g_chain
    assign pick_oh[i]  = cand[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | cand[i];
  end

  assign any = seen[W];
endmodule

// File: rtl/dpa_onehot_enc.sv
module dpa_onehot_enc #(
  parameter int unsigned W  = 14,
  parameter int unsigned IW = 4
) (
  input  logic [W-1:0]  oh,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (oh[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int unsigned NUM_CH = 14,
  localparam int unsigned CH_W  = dpa_pkg::idx_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              lvl_set_we,
  input  logic [NUM_CH-1:0] lvl_set_data,
  input  logic              lvl_clr_we,
  input  logic [NUM_CH-1:0] lvl_clr_data,
  input  logic              arb_pulse,
  output logic [NUM_CH-1:0] grant_oh,
  output logic [CH_W-1:0]   grant_ch,
  output logic              grant_vld
);
  logic [NUM_CH-1:0] lvl, elig, elig_hi;
  logic [NUM_CH-1:0] pick_hi, pick_all, pick_sel;
  logic              any_hi, any_all;
  logic [CH_W-1:0]   pick_idx;

  dpa_level_reg #(.W(NUM_CH)) u_lvl (
    .clk      (clk),
    .rst      (rst),
    .set_we   (lvl_set_we),
    .set_data (lvl_set_data),
    .clr_we   (lvl_clr_we),
    .clr_data (lvl_clr_data),
    .lvl      (lvl)
  );

  assign elig    = req & ch_en;
  assign elig_hi = elig & lvl;

  // Both tiers are resolved in parallel; the high tier overrides.
  dpa_low_pick #(.W(NUM_CH)) u_pick_hi (
    .cand (elig_hi), .pick_oh (pick_hi), .any (any_hi)
  );
  dpa_low_pick #(.W(NUM_CH)) u_pick_all (
    .cand (elig), .pick_oh (pick_all), .any (any_all)
  );

  assign pick_sel = any_hi ? pick_hi : pick_all;

  dpa_onehot_enc #(.W(NUM_CH), .IW(CH_W)) u_enc (
    .oh (pick_sel), .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_oh  <= '0;
      grant_ch  <= '0;
      grant_vld <= 1'b0;
    end else if (arb_pulse) begin
      grant_oh  <= pick_sel;
      grant_ch  <= pick_idx;
      grant_vld <= any_all;
    end
  end

  assert_hold_between_pulses_R9: assert property (@(posedge clk) disable iff (rst)
    !arb_pulse |=> ($stable(grant_oh) && $stable(grant_ch) && $stable(grant_vld)));

  assert_onehot_grant_R10: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> ($countones(grant_oh) == 1 && grant_oh[grant_ch]));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !grant_vld |-> (grant_oh == '0 && grant_ch == '0));

  assert_valid_tracks_elig_R8: assert property (@(posedge clk) disable iff (rst)
    arb_pulse |=> (grant_vld == $past(|(req & ch_en))));

  assert_masked_never_granted_R7: assert property (@(posedge clk) disable iff (rst)
    arb_pulse |=> ((grant_oh & ~$past(req & ch_en)) == '0));

  assert_high_tier_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (arb_pulse && |(req & ch_en & lvl)) |=> ((grant_oh & ~$past(lvl)) == '0));
endmodule

// File: tb/tb_dma_prio_arbiter.sv
module tb_dma_prio_arbiter;
  localparam int N = 6;
  localparam int CW = dpa_pkg::idx_width(N);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] req, ch_en, lvl_set_data, lvl_clr_data;
  logic lvl_set_we, lvl_clr_we, arb_pulse;
  logic [N-1:0] grant_oh;
  logic [CW-1:0] grant_ch;
  logic grant_vld;

  int n_chk = 0;
  int n_fail = 0;
  logic [N-1:0] m_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prio_arbiter #(.NUM_CH(N)) dut (
    .clk(clk), .rst(rst), .req(req), .ch_en(ch_en),
    .lvl_set_we(lvl_set_we), .lvl_set_data(lvl_set_data),
    .lvl_clr_we(lvl_clr_we), .lvl_clr_data(lvl_clr_data),
    .arb_pulse(arb_pulse), .grant_oh(grant_oh), .grant_ch(grant_ch),
    .grant_vld(grant_vld)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: high tier first, then lowest number.
  function automatic logic [N-1:0] ref_pick(input logic [N-1:0] r, input logic [N-1:0] e,
                                            input logic [N-1:0] l);
    logic [N-1:0] el, hi, c;
    el = r & e;
    hi = el & l;
    c = (hi != 0) ? hi : el;
    for (int i = 0; i < N; i++) if (c[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic int ref_idx(input logic [N-1:0] oh);
    for (int i = 0; i < N; i++) if (oh[i]) return i;
    return 0;
  endfunction

  task automatic write_lvl(input logic sw, input logic [N-1:0] sd,
                           input logic cw, input logic [N-1:0] cd);
    lvl_set_we = sw; lvl_set_data = sd; lvl_clr_we = cw; lvl_clr_data = cd;
    @(negedge clk);
    lvl_set_we = 0; lvl_clr_we = 0; lvl_set_data = '0; lvl_clr_data = '0;
    m_lvl = (m_lvl & ~(cw ? cd : '0)) | (sw ? sd : '0);
  endtask

  task automatic arb_check(input string tag, input logic [N-1:0] r, input logic [N-1:0] e);
    logic [N-1:0] exp_oh;
    exp_oh = ref_pick(r, e, m_lvl);
    req = r; ch_en = e; arb_pulse = 1;
    @(negedge clk);
    arb_pulse = 0;
    chk({tag, " grant_oh"}, 32'(grant_oh), 32'(exp_oh));
    chk({tag, " grant_vld (R8)"}, 32'(grant_vld), 32'((r & e) != 0));
    chk({tag, " grant_ch (R10)"}, 32'(grant_ch), 32'(ref_idx(exp_oh)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired, run hung (R9)");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst = 1; req = '0; ch_en = '0; arb_pulse = 0; m_lvl = '0;
    lvl_set_we = 0; lvl_clr_we = 0; lvl_set_data = '0; lvl_clr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", 32'(grant_vld), 0);
    chk("R1 oh in reset", 32'(grant_oh), 0);
    rst = 0;
    req = '1; ch_en = '1;
    repeat (2) @(negedge clk);
    chk("R1 vld before pulse", 32'(grant_vld), 0);
    chk("R1 ch before pulse", 32'(grant_ch), 0);
    // Levels all default after reset: requests from k upward grant k.
    for (int k = 0; k < N; k++) arb_check("R1 R6 reset levels", '1 << k, '1);

    // R9: hold between pulses while inputs move.
    arb_check("R9 setup", 6'b010100, '1);
    for (int c = 0; c < 4; c++) begin
      req = N'(c * 13 + 1); ch_en = N'(~c);
      @(negedge clk);
      chk("R9 hold oh", 32'(grant_oh), 32'(6'b000100));
      chk("R9 hold ch", 32'(grant_ch), 2);
    end
    // R9: level write on the pulse edge affects only later pulses.
    req = 6'b100001; ch_en = '1; arb_pulse = 1;
    lvl_set_we = 1; lvl_set_data = 6'b100000;
    @(negedge clk);
    arb_pulse = 0; lvl_set_we = 0; lvl_set_data = '0;
    chk("R9 same-edge write uses old level", 32'(grant_ch), 0);
    m_lvl = 6'b100000;
    arb_check("R9 R5 next pulse sees new level", 6'b100001, '1);

    // R2 / R3 zero bits and partial writes.
    write_lvl(1, 6'b000100, 1, '1);
    write_lvl(1, '0, 0, '0);
    arb_check("R2 zero set bits no effect", '1, '1);
    chk("R2 level 2 kept", 32'(grant_ch), 2);
    write_lvl(1, 6'b001000, 0, '0);
    arb_check("R2 second set", '1, '1);
    chk("R2 both high lowest wins", 32'(grant_ch), 2);
    write_lvl(0, '0, 1, '0);
    arb_check("R3 zero clr bits no effect", 6'b111011, '1);
    chk("R3 level 3 kept", 32'(grant_ch), 3);
    write_lvl(0, '0, 1, 6'b000100);
    arb_check("R3 clear", '1, '1);
    chk("R3 cleared channel loses", 32'(grant_ch), 3);
    // R4 collision.
    write_lvl(1, 6'b010000, 1, 6'b011000);
    arb_check("R4 set wins collision", '1, '1);
    chk("R4 channel 4 high", 32'(grant_ch), 4);
    write_lvl(0, '0, 1, '1);
    arb_check("R3 clear all", '1, '1);
    chk("R3 all default", 32'(grant_ch), 0);

    // R5 R6: every level pattern against every request pattern (set+clear-all, R4).
    for (int l = 0; l < (1 << N); l++) begin
      write_lvl(1, N'(l), 1, '1);
      for (int r = 0; r < (1 << N); r++) arb_check("R5 R6 sweep", N'(r), '1);
    end
    // R7 R8: every enable pattern against every request pattern.
    write_lvl(1, 6'b101010, 1, '1);
    for (int e = 0; e < (1 << N); e++)
      for (int r = 0; r < (1 << N); r++) arb_check("R7 R8 sweep", N'(r), N'(e));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule